// File: doc/BRIEF.md
# Oversampling Asynchronous Receiver

This block turns an asynchronous serial line into parallel characters. It works from a sample enable that runs at sixteen times the bit rate. It can instead take a receive clock at the bit rate and sample the line on that clock's rising edges. The start bit is detected from a falling edge and confirmed at mid-bit. Between five and eight data bits are assembled, least significant bit first. An optional parity bit and one stop bit are then checked.

Each received character comes out with parity-error, framing-error and break flags. A line held low for a whole frame produces a single break character and a break-start event. When the line later returns high, a break-end event follows. After an ordinary framing error, the receiver waits half a bit time and then accepts a low line level as the next start bit. This recovers characters that follow a low stop bit with no idle time. Every delivered character is also compared against a programmed character. A match raises a flag, and a second flag gated by an enable can feed an interrupt.

Top module: `async_rx_core`

## Requirements
- R1: `char_len_i` selects 5, 6, 7 or 8 data bits (codes 0 to 3). Data is received least significant bit first, and bits of `data_o` above the selected length read zero.
- R2: `par_mode_i` selects the parity check: 0 none, 1 even, 2 odd, 3 forced to the value of `par_force_i`. `par_err_o` is set when the received parity bit disagrees; with no parity it is always clear.
- R3: With `mode_1x_i`=0 the line is sampled only on cycles where `os_en_i` is high, sixteen samples per bit. With `mode_1x_i`=1 it is sampled once per bit, on each rising edge of `rxc_i`.
- R4: In 16x mode a start bit is confirmed on the 8th sample after the first low sample. If the line is high at that sample, the start is discarded and no character is produced.
- R5: A character whose stop bit is sampled low (and which is not a break) is delivered with `frm_err_o`=1. Half a bit time later (8 samples in 16x mode, at once in 1x mode) a low line level is accepted as a new start bit.
- R6: A frame whose data, parity and stop bits are all low is delivered as one character with `brk_o`=1, `data_o`=0 and `frm_err_o`=1. `brk_start_o` pulses in the same cycle.
- R7: While the break lasts, no further character is delivered. `brk_end_o` pulses once when the line is first sampled high again.
- R8: `match_o` is high with `valid_o` when the selected low data bits equal those of `cmp_char_i`. It never goes high for a break character.
- R9: `match_irq_o` is `match_o` gated by `cmp_irq_en_i`.
- R10: After reset all outputs are low.
- R11: `valid_o` is a one-cycle pulse per character. Every delivered character carries data and flags that match the received frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_1x_i | input | 1 | 1: sample on `rxc_i` rising edges; 0: use `os_en_i` |
| os_en_i | input | 1 | 16x sample enable, one cycle wide |
| rxc_i | input | 1 | Receive clock at the bit rate (1x mode) |
| rxd_i | input | 1 | Serial data line, idle high |
| char_len_i | input | 2 | Data bits minus five |
| par_mode_i | input | 2 | Parity mode code |
| par_force_i | input | 1 | Expected parity bit in forced mode |
| cmp_char_i | input | 8 | Character to compare against |
| cmp_irq_en_i | input | 1 | Enables `match_irq_o` |
| valid_o | output | 1 | Character delivered (pulse) |
| data_o | output | 8 | Received character |
| par_err_o | output | 1 | Parity error of the character |
| frm_err_o | output | 1 | Stop bit sampled low |
| brk_o | output | 1 | Character is a break |
| brk_start_o | output | 1 | Break detected (pulse) |
| brk_end_o | output | 1 | Line returned high after break (pulse) |
| match_o | output | 1 | Character equals compare value |
| match_irq_o | output | 1 | Gated match request |

## Verification
The assertions assume that `rxd_i`, `rxc_i` and `os_en_i` are already synchronous to `clk_i`. They also assume that `os_en_i` is a single-cycle pulse, that each phase of `rxc_i` lasts at least one core cycle, and that length, parity and compare settings change only while the line is idle. The bench keeps within these limits by changing every input on the falling core-clock edge. It holds each `rxc_i` phase for two cycles, spaces the enables two cycles apart, and reconfigures only between characters, with the line high. The corner cases covered are a short low glitch, a low stop bit followed at once by another start bit, and a line held low for several frame times.

// File: rtl/rx_pkg.sv
package rx_pkg;
  typedef enum logic [1:0] {
    PAR_NONE  = 2'd0,
    PAR_EVEN  = 2'd1,
    PAR_ODD   = 2'd2,
    PAR_FORCE = 2'd3
  } par_mode_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_START,
    S_DATA,
    S_PAR,
    S_STOP,
    S_BRK,
    S_HUNT
  } rx_state_e;
endpackage

// File: rtl/rx_tick_gen.sv
module rx_tick_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mode_1x_i,
  input  logic os_en_i,
  input  logic rxc_i,
  output logic tick_o
);
  logic rxc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rxc_q <= 1'b0;
    else         rxc_q <= rxc_i;
  end

  assign tick_o = mode_1x_i ? (rxc_i & ~rxc_q) : os_en_i;

  p_tick_1x_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_1x_i && tick_o) |-> (rxc_i && !$past(rxc_i)));
endmodule

// File: rtl/rx_frame.sv
module rx_frame import rx_pkg::*; #(
  parameter int OS_RATE = 16,
  parameter int DATA_W  = 8,
  parameter int LEN_MIN = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              mode_1x_i,
  input  logic              rxd_i,
  input  logic [1:0]        char_len_i,
  input  logic [1:0]        par_mode_i,
  input  logic              par_force_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic              par_err_o,
  output logic              frm_err_o,
  output logic              brk_o,
  output logic              brk_start_o,
  output logic              brk_end_o
);
  localparam int CNT_W = $clog2(OS_RATE);
  localparam int IDX_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] FULL_LAST = CNT_W'(OS_RATE - 1);
  localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(OS_RATE / 2 - 1);

  rx_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] shreg_q;
  logic              par_bit_q, line_q, level_ok_q;
  logic              valid_q, perr_q, ferr_q, brk_q, bstart_q, bend_q;
  logic [DATA_W-1:0] data_q;

  par_mode_e         pm;
  logic [IDX_W-1:0]  last_idx;
  logic [DATA_W-1:0] len_mask;
  logic              bit_last, half_last, perr, is_brk;

  assign pm        = par_mode_e'(par_mode_i);
  assign last_idx  = IDX_W'(LEN_MIN - 1) + IDX_W'(char_len_i);
  assign bit_last  = mode_1x_i | (cnt_q == FULL_LAST);
  assign half_last = mode_1x_i | (cnt_q == HALF_LAST);

  always_comb begin
    for (int i = 0; i < DATA_W; i++) len_mask[i] = (i <= int'(last_idx));
  end

  always_comb begin
    unique case (pm)
      PAR_EVEN:  perr = ^(shreg_q & len_mask) ^ par_bit_q;
      PAR_ODD:   perr = ~(^(shreg_q & len_mask) ^ par_bit_q);
      PAR_FORCE: perr = par_bit_q != par_force_i;
      default:   perr = 1'b0;
    endcase
  end

  // break: every bit of the frame low
  assign is_brk = !rxd_i && (shreg_q == '0) && (pm == PAR_NONE || !par_bit_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      cnt_q      <= '0;
      idx_q      <= '0;
      shreg_q    <= '0;
      par_bit_q  <= 1'b0;
      line_q     <= 1'b1;
      level_ok_q <= 1'b0;
      valid_q    <= 1'b0;
      data_q     <= '0;
      perr_q     <= 1'b0;
      ferr_q     <= 1'b0;
      brk_q      <= 1'b0;
      bstart_q   <= 1'b0;
      bend_q     <= 1'b0;
    end else begin
      valid_q  <= 1'b0;
      bstart_q <= 1'b0;
      bend_q   <= 1'b0;
      if (tick_i) begin
        line_q <= rxd_i;
        unique case (state_q)
          S_IDLE: begin
            if (rxd_i) level_ok_q <= 1'b0;
            else if (line_q || level_ok_q) begin
              level_ok_q <= 1'b0;
              shreg_q    <= '0;
              par_bit_q  <= 1'b0;
              idx_q      <= '0;
              cnt_q      <= '0;
              state_q    <= mode_1x_i ? S_DATA : S_START;
            end
          end
          S_START: begin
            if (half_last) begin
              cnt_q   <= '0;
              state_q <= rxd_i ? S_IDLE : S_DATA;
            end else cnt_q <= cnt_q + 1'b1;
          end
          S_DATA: begin
            if (bit_last) begin
              cnt_q          <= '0;
              shreg_q[idx_q] <= rxd_i;
              if (idx_q == last_idx) state_q <= (pm == PAR_NONE) ? S_STOP : S_PAR;
              else                   idx_q   <= idx_q + 1'b1;
            end else cnt_q <= cnt_q + 1'b1;
          end
          S_PAR: begin
            if (bit_last) begin
              cnt_q     <= '0;
              par_bit_q <= rxd_i;
              state_q   <= S_STOP;
            end else cnt_q <= cnt_q + 1'b1;
          end
          S_STOP: begin
            if (bit_last) begin
              cnt_q   <= '0;
              valid_q <= 1'b1;
              data_q  <= shreg_q;
              perr_q  <= perr;
              ferr_q  <= !rxd_i;
              brk_q   <= is_brk;
              if (is_brk) begin
                bstart_q <= 1'b1;
                state_q  <= S_BRK;
              end else if (!rxd_i) begin
                level_ok_q <= mode_1x_i;
                state_q    <= mode_1x_i ? S_IDLE : S_HUNT;
              end else state_q <= S_IDLE;
            end else cnt_q <= cnt_q + 1'b1;
          end
          S_HUNT: begin
            if (half_last) begin
              cnt_q      <= '0;
              level_ok_q <= 1'b1;
              state_q    <= S_IDLE;
            end else cnt_q <= cnt_q + 1'b1;
          end
          S_BRK: begin
            if (rxd_i) begin
              bend_q  <= 1'b1;
              state_q <= S_IDLE;
            end
          end
          default: state_q <= S_IDLE;
        endcase
      end
    end
  end

  assign valid_o     = valid_q;
  assign data_o      = data_q;
  assign par_err_o   = perr_q;
  assign frm_err_o   = ferr_q;
  assign brk_o       = brk_q;
  assign brk_start_o = bstart_q;
  assign brk_end_o   = bend_q;

  p_single_valid_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |=> !valid_q);
  p_false_start_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_START && tick_i && half_last && rxd_i) |=> (state_q == S_IDLE && !valid_q));
  p_brk_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_BRK && $past(state_q == S_BRK)) |-> !valid_q);
  p_brk_end_once_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bend_q |=> !bend_q);
endmodule

// File: rtl/rx_match.sv
module rx_match #(
  parameter int DATA_W  = 8,
  parameter int LEN_MIN = 5
) (
  input  logic              valid_i,
  input  logic              brk_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [DATA_W-1:0] cmp_i,
  input  logic [1:0]        char_len_i,
  input  logic              irq_en_i,
  output logic              match_o,
  output logic              irq_o
);
  logic [DATA_W-1:0] bit_ok;

  for (genvar i = 0; i < DATA_W; i++) begin : g_cmp
    assign bit_ok[i] = (data_i[i] == cmp_i[i]) || (i >= LEN_MIN + int'(char_len_i));
  end

  assign match_o = valid_i && !brk_i && (&bit_ok);
  assign irq_o   = match_o && irq_en_i;
endmodule

// File: rtl/async_rx_core.sv
module async_rx_core #(
  parameter int OS_RATE = 16,
  parameter int DATA_W  = 8,
  parameter int LEN_MIN = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_1x_i,
  input  logic              os_en_i,
  input  logic              rxc_i,
  input  logic              rxd_i,
  input  logic [1:0]        char_len_i,
  input  logic [1:0]        par_mode_i,
  input  logic              par_force_i,
  input  logic [DATA_W-1:0] cmp_char_i,
  input  logic              cmp_irq_en_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic              par_err_o,
  output logic              frm_err_o,
  output logic              brk_o,
  output logic              brk_start_o,
  output logic              brk_end_o,
  output logic              match_o,
  output logic              match_irq_o
);
  logic tick;

  rx_tick_gen u_tick (
    .clk_i, .rst_ni, .mode_1x_i, .os_en_i, .rxc_i, .tick_o(tick)
  );

  rx_frame #(.OS_RATE(OS_RATE), .DATA_W(DATA_W), .LEN_MIN(LEN_MIN)) u_frame (
    .clk_i, .rst_ni, .tick_i(tick), .mode_1x_i, .rxd_i, .char_len_i,
    .par_mode_i, .par_force_i, .valid_o, .data_o, .par_err_o, .frm_err_o,
    .brk_o, .brk_start_o, .brk_end_o
  );

  rx_match #(.DATA_W(DATA_W), .LEN_MIN(LEN_MIN)) u_match (
    .valid_i(valid_o), .brk_i(brk_o), .data_i(data_o), .cmp_i(cmp_char_i),
    .char_len_i, .irq_en_i(cmp_irq_en_i), .match_o, .irq_o(match_irq_o)
  );

  p_data_len_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ((data_o >> (LEN_MIN + int'(char_len_i))) == '0));
  p_match_valid_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> (valid_o && !brk_o));
  p_irq_gate_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_irq_o |-> (match_o && cmp_irq_en_i));
  p_brk_with_char_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_start_o |-> (valid_o && brk_o && frm_err_o && data_o == '0));
endmodule

// File: tb/tb_async_rx_core.sv
module tb_async_rx_core;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_1x = 1'b0, os_en = 1'b0, rxc = 1'b0, rxd = 1'b1;
  logic [1:0] char_len = 2'd3, par_mode = 2'd0;
  logic       par_force = 1'b0, cmp_en = 1'b0;
  logic [7:0] cmp_char = 8'h00;
  logic       valid, perr, ferr, brk, bstart, bend, match, mirq;
  logic [7:0] data;

  int n_checks = 0, n_bad = 0, obs_bs = 0, obs_be = 0;
  bit done = 1'b0;
  logic [12:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  async_rx_core dut (
    .clk_i(clk), .rst_ni(rst_n), .mode_1x_i(mode_1x), .os_en_i(os_en), .rxc_i(rxc),
    .rxd_i(rxd), .char_len_i(char_len), .par_mode_i(par_mode), .par_force_i(par_force),
    .cmp_char_i(cmp_char), .cmp_irq_en_i(cmp_en), .valid_o(valid), .data_o(data),
    .par_err_o(perr), .frm_err_o(ferr), .brk_o(brk), .brk_start_o(bstart),
    .brk_end_o(bend), .match_o(match), .match_irq_o(mirq)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // reference comparison on every clock, away from the active edge
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      if (rst_n) begin
        if (valid) begin
          if (exp_q.size() == 0) check(1'b0, "R11 unexpected character", {19'd0, match, mirq, brk, ferr, perr, data}, 32'd0);
          else begin
            logic [12:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check({match, mirq, brk, ferr, perr, data} == e, t, {19'd0, match, mirq, brk, ferr, perr, data}, {19'd0, e});
          end
        end else if (match || mirq) check(1'b0, "R8 match without character", {30'd0, match, mirq}, 32'd0);
        if (bstart) obs_bs++;
        if (bend)   obs_be++;
      end
    end
  end

  task automatic os_tick();
    @(negedge clk) os_en = 1'b1;
    @(negedge clk) os_en = 1'b0;
  endtask

  task automatic send_bit(input logic b, input bit x1);
    if (!x1) begin
      @(negedge clk) rxd = b;
      repeat (16) os_tick();
    end else begin
      @(negedge clk) begin rxd = b; rxc = 1'b0; end
      repeat (2) @(negedge clk);
      rxc = 1'b1;
      repeat (2) @(negedge clk);
    end
  endtask

  task automatic send_char(input int len, input int pm, input logic [7:0] d,
                           input bit bad_par, input logic stop_v, input bit x1, input string tag);
    logic [7:0] mask, dm;
    logic pbit, is_brk, mt;
    mask = 8'((1 << len) - 1);
    dm = d & mask;
    case (pm)
      1: pbit = ^dm;
      2: pbit = ~^dm;
      3: pbit = par_force;
      default: pbit = 1'b0;
    endcase
    if (bad_par) pbit = ~pbit;
    is_brk = (dm == 8'd0) && !stop_v && (pm == 0 || !pbit);
    mt = !is_brk && (((d ^ cmp_char) & mask) == 8'd0);
    exp_q.push_back({mt, mt & cmp_en, is_brk, !stop_v, (pm != 0) && bad_par, dm});
    tag_q.push_back(tag);
    send_bit(1'b0, x1);
    for (int i = 0; i < len; i++) send_bit(d[i], x1);
    if (pm != 0) send_bit(pbit, x1);
    send_bit(stop_v, x1);
  endtask

  task automatic setup(input bit x1, input int len, input int pm);
    @(negedge clk);
    mode_1x = x1;
    char_len = 2'(len - 5);
    par_mode = 2'(pm);
    repeat (2) send_bit(1'b1, x1);
  endtask

  task automatic drained(input string req);
    repeat (4) send_bit(1'b1, mode_1x);
    check(exp_q.size() == 0, req, exp_q.size(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check({valid, data, perr, ferr, brk, bstart, bend, match, mirq} == 16'd0, "R10 reset outputs",
          {16'd0, valid, data, perr, ferr, brk, bstart, bend, match, mirq}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check({valid, bstart, bend, match, mirq} == 5'd0, "R10 idle after reset", {27'd0, valid, bstart, bend, match, mirq}, 0);

    // R1 / R3 lengths in 16x mode
    setup(1'b0, 8, 0);
    send_char(8, 0, 8'hA5, 0, 1, 0, "R1 8-bit char");
    send_char(8, 0, 8'h01, 0, 1, 0, "R1 lsb first");
    setup(1'b0, 5, 0);
    send_char(5, 0, 8'hF3, 0, 1, 0, "R1 5-bit char upper zero");
    drained("R1 all characters seen");

    // R2 parity modes
    setup(1'b0, 7, 1);
    send_char(7, 1, 8'h35, 0, 1, 0, "R2 even good");
    send_char(7, 1, 8'h35, 1, 1, 0, "R2 even bad");
    setup(1'b0, 7, 2);
    send_char(7, 2, 8'h6C, 0, 1, 0, "R2 odd good");
    send_char(7, 2, 8'h6C, 1, 1, 0, "R2 odd bad");
    par_force = 1'b1;
    setup(1'b0, 6, 3);
    send_char(6, 3, 8'h2A, 0, 1, 0, "R2 forced good");
    send_char(6, 3, 8'h2A, 1, 1, 0, "R2 forced bad");
    drained("R2 all characters seen");

    // R4 false start: low for 4 samples only
    setup(1'b0, 8, 0);
    @(negedge clk) rxd = 1'b0;
    repeat (4) os_tick();
    @(negedge clk) rxd = 1'b1;
    repeat (24) os_tick();
    check(exp_q.size() == 0 && !valid, "R4 glitch rejected", {31'd0, valid}, 0);
    send_char(8, 0, 8'h5C, 0, 1, 0, "R4 char after glitch");
    drained("R4 char after glitch seen");

    // R3 enable ignored: os_en held low, line toggled, nothing received
    @(negedge clk) rxd = 1'b0;
    repeat (40) @(negedge clk);
    rxd = 1'b1;
    repeat (40) @(negedge clk);
    check(obs_bs == 0 && exp_q.size() == 0, "R3 no sampling without enable", obs_bs, 0);

    // R5 framing error followed at once by a start bit
    send_char(8, 0, 8'h5A, 0, 0, 0, "R5 framing error flagged");
    send_char(8, 0, 8'h3C, 0, 1, 0, "R5 recovered char");
    drained("R5 recovery");

    // R8 / R9 compare
    cmp_char = 8'h41; cmp_en = 1'b1;
    send_char(8, 0, 8'h41, 0, 1, 0, "R9 match with irq");
    send_char(8, 0, 8'h42, 0, 1, 0, "R8 no match");
    cmp_en = 1'b0;
    send_char(8, 0, 8'h41, 0, 1, 0, "R9 irq disabled");
    setup(1'b0, 5, 0);
    send_char(5, 0, 8'h01, 0, 1, 0, "R8 match on low bits");
    drained("R8 compare chars seen");

    // R6 / R7 break over several frame times
    setup(1'b0, 8, 0);
    cmp_char = 8'h00; cmp_en = 1'b1;
    exp_q.push_back({1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00});
    tag_q.push_back("R6 break char");
    repeat (25) send_bit(1'b0, 1'b0);
    check(obs_bs == 1 && obs_be == 0, "R6 break start once", obs_bs, 1);
    repeat (3) send_bit(1'b1, 1'b0);
    check(obs_be == 1, "R7 break end once", obs_be, 1);
    cmp_char = 8'h77;
    send_char(8, 0, 8'h77, 0, 1, 0, "R7 char after break");
    drained("R7 no extra chars");

    // R3 1x mode
    cmp_en = 1'b0;
    setup(1'b1, 8, 1);
    send_char(8, 1, 8'hC3, 0, 1, 1, "R3 1x even char");
    setup(1'b1, 5, 0);
    send_char(5, 0, 8'h13, 0, 1, 1, "R3 1x 5-bit char");
    send_char(5, 0, 8'h09, 0, 0, 1, "R5 1x framing error");
    send_char(5, 0, 8'h16, 0, 1, 1, "R5 1x recovered char");
    drained("R3 1x chars seen");

    check(obs_bs == 1 && obs_be == 1, "R7 break events total", {obs_bs[15:0], obs_be[15:0]}, 32'h0001_0001);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_checks++;
      n_bad++;
      $display("FAIL watchdog R11 actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", n_checks, n_bad);
      $finish;
    end
  end
endmodule